// File: doc/BRIEF.md
# Dual-Path Divider Configuration Latch

This block holds the divider settings that a frequency synthesizer's downstream dividers consume. There is a 9-bit feedback divider value and a 2-bit post-divider select. Either of two sources can write these settings. One is an 11-bit serial shift register, fed by a serial data pin and stepped by a serial clock pin. The other is a group of parallel pins that carry both fields directly.

Each source has its own load control, and the two controls have opposite polarity. The serial load control opens the latches while it is high and closes them on its falling edge. The parallel load control opens the latches while it is low and closes them on its rising edge. While a path is open, the outputs track that path's value in the same cycle. When the path closes, the outputs keep the last value they showed.

The latches are modelled as a register that refreshes every `clk` cycle, with a bypass while open. All control pins are plain levels sampled in the `clk` domain. There is no stream interface and no back-pressure, because a configuration word has no flow to throttle.

Top module: `cfg_divider_latch`

## Requirements
- R1: After reset, with the load controls at their idle levels (serial load 0, parallel load 1), the outputs read feedback value 511 and post-divider select 3 (all ones).
- R2: While `par_load` is 0, `div_m` equals `par_m` and `div_n` equals `par_n` in the same cycle.
- R3: When `par_load` rises, the outputs keep the parallel value of the last cycle in which it was low. Later changes on `par_m`/`par_n` have no effect while both paths stay closed.
- R4: While `ser_load` is 1 and `par_load` is 1, `div_n` equals shift register bits [10:9] and `div_m` equals bits [8:0].
- R5: When `ser_load` falls, the outputs keep the shift register value of the last cycle in which it was high.
- R6: On each rising edge of `ser_clk` (seen in the `clk` domain), the shift register moves left by one and takes `ser_data` into bit 0. An 11-bit word is therefore sent MSB first: N[1], N[0], then M[8] down to M[0].
- R7: When `par_load` is 0 and `ser_load` is 1 together, the parallel value drives the outputs.
- R8: While both paths are closed, shifting on `ser_clk` and changes on the parallel pins leave the outputs unchanged.
- R9: The parallel path is level sensitive. While `par_load` stays 0, every change on `par_m`/`par_n` shows up on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all registers |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock; its rising edge shifts |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load control; latches open while high |
| par_load | input | 1 | Parallel load control; latches open while low |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel post-divider select |
| div_m | output | 9 | Latched feedback divider value |
| div_n | output | 2 | Latched post-divider select |

## Verification
The bench targets four kinds of error:
- **Closing edge.** A design that captures one cycle late, or that captures the new pin value on the closing edge, shows the wrong word right after `par_load` rises or `ser_load` falls.
- **Bit order and field split.** The bench shifts random words and opens the serial path. A reversed shift or swapped fields then shows a scrambled M or N.
- **Simultaneous open.** Both paths are opened together. A design that gives priority to the serial path shows the shift register value instead of the pins.
- **Closed state.** The bench shifts and wiggles the pins while both paths are closed. This catches latches that are wrongly transparent, and parallel capture that is edge-triggered instead of level-sensitive.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  // Which value drives the configuration outputs this cycle.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SER  = 2'd1,
    SRC_PAR  = 2'd2
  } cfg_src_e;

  // Parallel path outranks the serial path when both are open.
  function automatic cfg_src_e pick_source(input logic par_open, input logic ser_open);
    if (par_open)      return SRC_PAR;
    else if (ser_open) return SRC_SER;
    else               return SRC_HOLD;
  endfunction

endpackage

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [WORD_W-1:0] word
);

  logic ser_clk_q;
  logic ser_rise;

  // Rising edge of the serial clock as seen from clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_clk_q <= 1'b0;
    else        ser_clk_q <= ser_clk;
  end

  assign ser_rise = ser_clk & ~ser_clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (ser_rise) word <= {word[WORD_W-2:0], ser_data};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rise |=> (word[0] == $past(ser_data)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0]))); // R6
  AST_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_rise |=> $stable(word)); // R6

endmodule

// File: rtl/cfgl_latch.sv
module cfgl_latch
  import cfgl_pkg::*;
#(
  parameter int               WORD_W  = 11,
  parameter logic [WORD_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_open,
  input  logic              ser_open,
  input  logic [WORD_W-1:0] par_word,
  input  logic [WORD_W-1:0] ser_word,
  output logic [WORD_W-1:0] cfg_out
);

  cfg_src_e          src;
  logic [WORD_W-1:0] held_q;

  always_comb begin
    src = pick_source(par_open, ser_open);
    unique case (src)
      SRC_PAR: cfg_out = par_word;
      SRC_SER: cfg_out = ser_word;
      default: cfg_out = held_q;
    endcase
  end

  // Refresh every cycle: the value shown while open is what remains on close.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= RST_VAL;
    else        held_q <= cfg_out;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_HOLD) |=> ((src != SRC_HOLD) || $stable(cfg_out))); // R8
  AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_open && ser_open) |-> (cfg_out == par_word)); // R7

endmodule

// File: rtl/cfg_divider_latch.sv
module cfg_divider_latch #(
  parameter int M_W = 9,
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] div_m,
  output logic [N_W-1:0] div_n
);

  localparam int WORD_W = M_W + N_W;

  logic [WORD_W-1:0] sh_word;
  logic [WORD_W-1:0] cfg_word;

  cfgl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .word     (sh_word)
  );

  cfgl_latch #(.WORD_W(WORD_W), .RST_VAL('1)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_open (~par_load),
    .ser_open (ser_load),
    .par_word ({par_n, par_m}),
    .ser_word (sh_word),
    .cfg_out  (cfg_word)
  );

  assign div_n = cfg_word[WORD_W-1:M_W];
  assign div_m = cfg_word[M_W-1:0];

  AST_PAR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |-> ({div_n, div_m} == {par_n, par_m})); // R2
  AST_SER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && par_load) |-> ({div_n, div_m} == sh_word)); // R4
  AST_PAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(par_load) && !ser_load) |-> ({div_n, div_m} == $past({par_n, par_m}))); // R3
  AST_SER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_load) && par_load && $past(par_load)) |-> ({div_n, div_m} == $past(sh_word))); // R5

endmodule

// File: tb/cfg_divider_latch_tb.sv
`timescale 1ns/1ps
module cfg_divider_latch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b1;
  logic [8:0] par_m = '1;
  logic [1:0] par_n = '1;
  logic [8:0] div_m;
  logic [1:0] div_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [10:0] exp_sh = '0;  // bench model of the shift register
  logic [10:0] exp_out = '1; // bench model of the latched word

  always #10 clk = ~clk;

  cfg_divider_latch dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .div_m(div_m), .div_n(div_n)
  );

  function automatic logic [10:0] shifted(input logic [10:0] cur, input logic b);
    return {cur[9:0], b};
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [10:0] exp);
    #1;
    n_chk++;
    if ({div_n, div_m} !== exp) begin
      n_bad++;
      $display("FAIL %s: got n=%0d m=%0d, expected n=%0d m=%0d", req,
               div_n, div_m, exp[10:9], exp[8:0]);
    end
  endtask

  // R2, R3: open parallel path, then close it and change the pins.
  task automatic par_write(input logic [10:0] w);
    par_load = 1'b0; {par_n, par_m} = w;
    check("R2", w);
    tick();
    par_load = 1'b1; {par_n, par_m} = ~w;
    exp_out = w;
    check("R3", exp_out);
    tick();
    check("R3", exp_out);
  endtask

  // R6, R8: shift a word MSB first with both paths closed.
  task automatic ser_shift(input logic [10:0] w);
    for (int i = 10; i >= 0; i--) begin
      ser_data = w[i]; ser_clk = 1'b1;
      tick();
      exp_sh = shifted(exp_sh, w[i]);
      ser_clk = 1'b0;
      tick();
    end
    check("R8", exp_out);
  endtask

  // R4, R5: open and close the serial path.
  task automatic ser_commit();
    ser_load = 1'b1;
    check("R4", exp_sh);
    tick();
    ser_load = 1'b0;
    exp_out = exp_sh;
    check("R5", exp_out);
    tick();
    check("R5", exp_out);
  endtask

  initial begin
    logic [10:0] w;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1", 11'h7ff);

    // Directed: known serial word N=2, M=0x0A5.
    ser_shift({2'b10, 9'h0a5});
    check("R6", exp_out);
    ser_commit();
    if (exp_out != {2'b10, 9'h0a5}) begin n_bad++; $display("FAIL R6: model mismatch"); end

    // Directed: both open -> parallel wins, then serial alone takes over.
    ser_load = 1'b1; par_load = 1'b0; {par_n, par_m} = 11'h15a;
    check("R7", 11'h15a);
    tick();
    check("R7", 11'h15a);
    par_load = 1'b1;
    check("R4", exp_sh);
    tick();
    ser_load = 1'b0; exp_out = exp_sh;
    tick();

    // Directed: level sensitivity.
    par_load = 1'b0;
    for (int k = 0; k < 3; k++) begin
      w = 11'($urandom());
      {par_n, par_m} = w;
      check("R9", w);
      tick();
    end
    par_load = 1'b1; exp_out = w;
    {par_n, par_m} = 11'h000;
    check("R3", exp_out);
    tick();

    // Closed: wiggle pins, outputs hold.
    for (int k = 0; k < 4; k++) begin
      {par_n, par_m} = 11'($urandom());
      tick();
      check("R8", exp_out);
    end

    // Random mix.
    for (int it = 0; it < 60; it++) begin
      w = 11'($urandom());
      case ($urandom_range(0, 2))
        0: par_write(w);
        1: begin ser_shift(w); ser_commit(); end
        default: begin
          ser_load = 1'b1; par_load = 1'b0; {par_n, par_m} = w;
          check("R7", w);
          tick();
          par_load = 1'b1; ser_load = 1'b0; exp_out = w;
          check("R3", exp_out);
          tick();
        end
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule